// File: doc/BRIEF.md
# Single-Item DMA Transfer Engine

This block moves data for several request channels. Each channel carries its own configuration: source and destination base addresses, a separate auto-increment enable for each of the two pointers, an item size, an item count and a circular-mode flag. A peripheral raises its channel's request line. When the engine is idle, it grants the lowest-numbered enabled channel that is requesting. It then runs one fixed sequence for that request: an arbitration cycle, an address cycle, a single read from the source, a single write of that same data to the destination, one cycle with the bus left free, and one acknowledge cycle that closes the handshake with the peripheral.

The engine never bursts. Every request moves exactly one item, so another bus master never waits longer than one bus tenure. Because the source and destination are plain addresses, memory-to-memory, memory-to-peripheral, peripheral-to-memory and peripheral-to-peripheral transfers are all the same operation. When a block ends, the channel either reloads its addresses and count (circular mode) or disables itself. The engine reaches memory through a single-beat master port with a wait-ready input. Channels are loaded through a one-cycle configuration write strobe.

Top module: `dma_xfer_engine`

## Requirements
- R1: A granted request makes exactly one bus read at the source pointer (busWe=0). The next bus cycle is one write at the destination pointer (busWe=1), and busWdata equals the busRdata captured when the read completed. No other bus cycle follows for that request.
- R2: Suppose the engine is idle and an enabled channel's request is high in cycle t. Then busReq is low in cycle t+1 (address cycle) and the read is presented in cycle t+2.
- R3: In the cycle after the write completes, both busReq and chAck are low (bus free). In the cycle after that, chAck has only the granted channel's bit high, for exactly one cycle, and busReq is low.
- R4: While busReq is high and busReady is low, busAddr, busWe, busSize and busWdata hold their values and the phase is extended. A phase completes in a cycle where busReady is high.
- R5: busSize shows the channel's size code: 0 means 8 bits, 1 means 16 bits, 2 means 32 bits. After each item, a pointer whose increment enable is set advances by 1, 2 or 4. A pointer whose enable is clear stays at its base.
- R6: A count value N gives N items per block. N=0 gives 2**CNT_W items. chDone has the channel's bit high only in the acknowledge cycle of the block's last item.
- R7: In circular mode, the item after a block's last item uses the base addresses again and a fresh count.
- R8: In non-circular mode, the channel disables itself after the last item. Later requests on it produce no bus cycle and no acknowledge.
- R9: When several enabled channels request while the engine is idle, the lowest channel index is served first. A channel configured with enable=0 is never served.
- R10: A request that arrives while another channel is being served waits. It is served only after the current acknowledge cycle has ended.
- R11: During and right after reset, busReq, chAck and chDone are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Loads one channel's configuration |
| cfgCh | input | CH_W | Channel being configured |
| cfgSrc | input | AW | Source base address |
| cfgDst | input | AW | Destination base address |
| cfgSrcInc | input | 1 | Source pointer increment enable |
| cfgDstInc | input | 1 | Destination pointer increment enable |
| cfgSize | input | 2 | Item size code (0=8, 1=16, 2=32 bits) |
| cfgCount | input | CNT_W | Items per block, 0 means 2**CNT_W |
| cfgCirc | input | 1 | Circular mode |
| cfgEnable | input | 1 | Channel enable |
| chReq | input | NUM_CH | Peripheral request lines |
| chAck | output | NUM_CH | One-cycle acknowledge per channel |
| chDone | output | NUM_CH | One-cycle end-of-block pulse |
| busReq | output | 1 | Bus cycle valid |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | AW | Bus address |
| busSize | output | 2 | Item size code of the access |
| busWdata | output | DW | Write data |
| busRdata | input | DW | Read data |
| busReady | input | 1 | Completes the current bus phase |

## Verification
The last item of a block is the case where two things land on one edge. In the same acknowledge cycle, the engine must raise chAck and chDone together and also either reload the pointers (circular) or clear the enable (non-circular). The vector table provokes this with counts of 1, 2, 3 and the full-range value 0. Each outcome is judged at the ports: the next request must again show the base addresses, or it must produce no bus cycle at all. A second overlap comes from a request on one channel that arrives while another channel is being served. The bench raises two requests on the same edge and checks that the second read starts only after the first acknowledge.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_FREE  = 3'd4,
    ST_ACK   = 3'd5
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic grantLoad;
    logic useDst;
    logic captureRd;
    logic finishItem;
  } engStrobe_t;

  function automatic logic [2:0] stepOf(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    stepOf = 3'd1;
      2'd1:    stepOf = 3'd2;
      default: stepOf = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_eng_ctrl.sv
module dma_eng_ctrl
  import dma_eng_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chEnabled,
  input  logic              busReady,
  output engStrobe_t        strobe,
  output logic [CH_W-1:0]   grantIdx,
  output logic              busReq,
  output logic              busWe,
  output logic [NUM_CH-1:0] chAck
);

  engState_e state, nextState;
  logic [NUM_CH-1:0] pending;
  logic [CH_W-1:0]   pickIdx;
  logic              pickAny;

  assign pending = chReq & chEnabled;

  // lowest index wins
  always_comb begin
    pickIdx = '0;
    pickAny = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pickIdx = CH_W'(i);
        pickAny = 1'b1;
      end
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:  if (pickAny) nextState = ST_ADDR;
      ST_ADDR:  nextState = ST_READ;
      ST_READ:  if (busReady) nextState = ST_WRITE;
      ST_WRITE: if (busReady) nextState = ST_FREE;
      ST_FREE:  nextState = ST_ACK;
      ST_ACK:   nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      grantIdx <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && pickAny) grantIdx <= pickIdx;
    end
  end

  always_comb begin
    strobe.grantLoad  = (state == ST_IDLE) && pickAny;
    strobe.useDst     = (state == ST_WRITE);
    strobe.captureRd  = (state == ST_READ) && busReady;
    strobe.finishItem = (state == ST_ACK);
    busReq            = (state == ST_READ) || (state == ST_WRITE);
    busWe             = (state == ST_WRITE);
    for (int i = 0; i < NUM_CH; i++) begin
      chAck[i] = (state == ST_ACK) && (grantIdx == CH_W'(i));
    end
  end

endmodule

// File: rtl/dma_eng_datapath.sv
module dma_eng_datapath
  import dma_eng_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [AW-1:0]     cfgSrc,
  input  logic [AW-1:0]     cfgDst,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic [1:0]        cfgSize,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgCirc,
  input  logic              cfgEnable,
  input  engStrobe_t        strobe,
  input  logic [CH_W-1:0]   grantIdx,
  input  logic [DW-1:0]     busRdata,
  output logic [NUM_CH-1:0] chEnabled,
  output logic [NUM_CH-1:0] chDone,
  output logic [AW-1:0]     busAddr,
  output logic [1:0]        busSize,
  output logic [DW-1:0]     busWdata
);

  logic [AW-1:0]    srcBase [NUM_CH];
  logic [AW-1:0]    dstBase [NUM_CH];
  logic [AW-1:0]    srcPtr  [NUM_CH];
  logic [AW-1:0]    dstPtr  [NUM_CH];
  logic [CNT_W-1:0] cntLoad [NUM_CH];
  logic [CNT_W-1:0] cntLeft [NUM_CH];
  logic [1:0]       sizeCode[NUM_CH];
  logic [NUM_CH-1:0] srcInc, dstInc, circ, enab;
  logic [DW-1:0]    dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        srcBase[c]  <= '0;
        dstBase[c]  <= '0;
        srcPtr[c]   <= '0;
        dstPtr[c]   <= '0;
        cntLoad[c]  <= '0;
        cntLeft[c]  <= '0;
        sizeCode[c] <= '0;
      end
      srcInc <= '0;
      dstInc <= '0;
      circ   <= '0;
      enab   <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfgWe && cfgCh == CH_W'(c)) begin
          srcBase[c]  <= cfgSrc;
          dstBase[c]  <= cfgDst;
          srcPtr[c]   <= cfgSrc;
          dstPtr[c]   <= cfgDst;
          cntLoad[c]  <= cfgCount;
          cntLeft[c]  <= cfgCount;
          sizeCode[c] <= cfgSize;
          srcInc[c]   <= cfgSrcInc;
          dstInc[c]   <= cfgDstInc;
          circ[c]     <= cfgCirc;
          enab[c]     <= cfgEnable;
        end else if (strobe.finishItem && grantIdx == CH_W'(c)) begin
          if (cntLeft[c] == CNT_W'(1) && circ[c]) begin
            srcPtr[c]  <= srcBase[c];
            dstPtr[c]  <= dstBase[c];
            cntLeft[c] <= cntLoad[c];
          end else begin
            if (srcInc[c]) srcPtr[c] <= srcPtr[c] + AW'(stepOf(sizeCode[c]));
            if (dstInc[c]) dstPtr[c] <= dstPtr[c] + AW'(stepOf(sizeCode[c]));
            cntLeft[c] <= cntLeft[c] - CNT_W'(1);
            if (cntLeft[c] == CNT_W'(1)) enab[c] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else if (strobe.captureRd) dataReg <= busRdata;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      chDone[c] = strobe.finishItem && (grantIdx == CH_W'(c)) && (cntLeft[c] == CNT_W'(1));
    end
  end

  assign chEnabled = enab;
  assign busAddr   = strobe.useDst ? dstPtr[grantIdx] : srcPtr[grantIdx];
  assign busSize   = sizeCode[grantIdx];
  assign busWdata  = dataReg;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [AW-1:0]     cfgSrc,
  input  logic [AW-1:0]     cfgDst,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic [1:0]        cfgSize,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgCirc,
  input  logic              cfgEnable,
  input  logic [NUM_CH-1:0] chReq,
  output logic [NUM_CH-1:0] chAck,
  output logic [NUM_CH-1:0] chDone,
  output logic              busReq,
  output logic              busWe,
  output logic [AW-1:0]     busAddr,
  output logic [1:0]        busSize,
  output logic [DW-1:0]     busWdata,
  input  logic [DW-1:0]     busRdata,
  input  logic              busReady
);

  engStrobe_t        strobe;
  logic [CH_W-1:0]   grantIdx;
  logic [NUM_CH-1:0] chEnabled;

  dma_eng_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) ctrlInst (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chEnabled(chEnabled),
    .busReady(busReady), .strobe(strobe), .grantIdx(grantIdx),
    .busReq(busReq), .busWe(busWe), .chAck(chAck)
  );

  dma_eng_datapath #(.NUM_CH(NUM_CH), .CH_W(CH_W), .AW(AW), .DW(DW), .CNT_W(CNT_W)) dpInst (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSrc(cfgSrc),
    .cfgDst(cfgDst), .cfgSrcInc(cfgSrcInc), .cfgDstInc(cfgDstInc),
    .cfgSize(cfgSize), .cfgCount(cfgCount), .cfgCirc(cfgCirc),
    .cfgEnable(cfgEnable), .strobe(strobe), .grantIdx(grantIdx),
    .busRdata(busRdata), .chEnabled(chEnabled), .chDone(chDone),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata)
  );

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 32,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chAck,
  input logic [NUM_CH-1:0] chDone,
  input logic              busReq,
  input logic              busWe,
  input logic [AW-1:0]     busAddr,
  input logic [1:0]        busSize,
  input logic [DW-1:0]     busWdata,
  input logic              busReady
);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busAddr) && $stable(busWe)
                               && $stable(busSize) && $stable(busWdata)));

  // R3
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chAck));

  // R3
  ack_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chAck) |-> (!busReq && !$past(busReq)));

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chAck) |=> (chAck == '0));

  // R6
  done_in_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chDone) |-> ((chDone & ~chAck) == '0));

  // R1
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && !$past(busReq && busWe)) |-> $past(busReq && !busWe && busReady));

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) chkInst (
  .clk(clk), .rstN(rstN), .chAck(chAck), .chDone(chDone), .busReq(busReq),
  .busWe(busWe), .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
  .busReady(busReady)
);

// File: tb/dma_xfer_engine_test.sv
`timescale 1ns/1ps
module dma_xfer_engine_test;

  localparam int NCH = 4;
  localparam int CW  = 4;

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] src;
    logic [31:0] dst;
    logic        sInc;
    logic        dInc;
    logic [1:0]  size;
    logic [3:0]  cnt;
    logic        circ;
    logic [1:0]  wR;
    logic [1:0]  wW;
    logic [4:0]  items;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 32'h0000_1000, 32'h0000_2000, 1'b1, 1'b1, 2'd2, 4'd3, 1'b0, 2'd0, 2'd0, 5'd3},
    '{2'd1, 32'h4000_0010, 32'h0000_3000, 1'b0, 1'b1, 2'd1, 4'd2, 1'b1, 2'd1, 2'd0, 5'd5},
    '{2'd2, 32'h0000_5000, 32'h4000_0020, 1'b1, 1'b0, 2'd0, 4'd4, 1'b0, 2'd0, 2'd2, 5'd4},
    '{2'd3, 32'h4000_0040, 32'h4000_0050, 1'b0, 1'b0, 2'd2, 4'd1, 1'b1, 2'd2, 2'd1, 5'd2},
    '{2'd0, 32'h0000_8000, 32'h0000_9000, 1'b1, 1'b1, 2'd2, 4'd0, 1'b0, 2'd0, 2'd0, 5'd16},
    '{2'd1, 32'h0000_A000, 32'h0000_B000, 1'b1, 1'b1, 2'd1, 4'd5, 1'b0, 2'd1, 2'd1, 5'd5}
  };

  logic clk = 0, rstN = 0;
  logic cfgWe = 0;
  logic [1:0] cfgCh = 0;
  logic [31:0] cfgSrc = 0, cfgDst = 0;
  logic cfgSrcInc = 0, cfgDstInc = 0, cfgCirc = 0, cfgEnable = 0;
  logic [1:0] cfgSize = 0;
  logic [CW-1:0] cfgCount = 0;
  logic [NCH-1:0] chReq = 0;
  logic [NCH-1:0] chAck, chDone;
  logic busReq, busWe, busReady = 0;
  logic [31:0] busAddr, busWdata, busRdata = 0;
  logic [1:0] busSize;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dma_xfer_engine #(.NUM_CH(NCH), .AW(32), .DW(32), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSrc(cfgSrc),
    .cfgDst(cfgDst), .cfgSrcInc(cfgSrcInc), .cfgDstInc(cfgDstInc),
    .cfgSize(cfgSize), .cfgCount(cfgCount), .cfgCirc(cfgCirc),
    .cfgEnable(cfgEnable), .chReq(chReq), .chAck(chAck), .chDone(chDone),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] ch, input logic [31:0] src, input logic [31:0] dst,
                           input logic sInc, input logic dInc, input logic [1:0] size,
                           input logic [CW-1:0] cnt, input logic circ, input logic en);
    cfgCh = ch; cfgSrc = src; cfgDst = dst; cfgSrcInc = sInc; cfgDstInc = dInc;
    cfgSize = size; cfgCount = cnt; cfgCirc = circ; cfgEnable = en; cfgWe = 1;
    @(negedge clk);
    cfgWe = 0;
  endtask

  // one request, starting at a negedge with the engine idle
  task automatic serve(input logic [1:0] ch, input logic [31:0] eSrc, input logic [31:0] eDst,
                       input logic [1:0] eSize, input int wR, input int wW,
                       input bit eDone, input logic [31:0] rdv);
    chReq[ch] = 1'b1;
    @(negedge clk);
    chk(!busReq, "R2 address cycle without bus", 32'(busReq), 0);
    @(negedge clk);
    chk(busReq && !busWe, "R2 read presented two cycles after request", {busReq, busWe}, 2'b10);
    chk(busAddr == eSrc, "R5 source address", busAddr, eSrc);
    chk(busSize == eSize, "R5 size code", 32'(busSize), 32'(eSize));
    for (int i = 0; i < wR; i++) begin
      busReady = 0;
      @(negedge clk);
      chk(busReq && !busWe && busAddr == eSrc, "R4 read held while not ready", busAddr, eSrc);
    end
    busReady = 1; busRdata = rdv;
    @(negedge clk);
    busReady = 0; busRdata = 32'hDEAD_BEEF;
    chk(busReq && busWe, "R1 write follows read", {busReq, busWe}, 2'b11);
    chk(busAddr == eDst, "R5 destination address", busAddr, eDst);
    chk(busWdata == rdv, "R1 write data equals read data", busWdata, rdv);
    for (int i = 0; i < wW; i++) begin
      @(negedge clk);
      chk(busReq && busWe && busAddr == eDst && busWdata == rdv, "R4 write held while not ready", busWdata, rdv);
    end
    busReady = 1;
    @(negedge clk);
    busReady = 0;
    chk(!busReq && chAck == 0, "R3 bus free cycle", {busReq, chAck}, 0);
    @(negedge clk);
    chk(chAck == 4'(1 << ch) && !busReq, "R3 acknowledge", 32'(chAck), 32'(1 << ch));
    chk(chDone == (eDone ? 4'(1 << ch) : 4'd0), "R6 done pulse", 32'(chDone), eDone ? 32'(1 << ch) : 0);
    chReq[ch] = 1'b0;
    @(negedge clk);
    chk(chAck == 0 && chDone == 0 && !busReq, "R3 acknowledge lasts one cycle", {chAck, chDone}, 0);
  endtask

  task automatic expectSilent(input logic [1:0] ch, input string req);
    chReq[ch] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busReq && chAck == 0, req, {busReq, chAck}, 0);
    end
    chReq[ch] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busReq && chAck == 0 && chDone == 0, "R11 outputs quiet in reset", {busReq, chAck, chDone}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!busReq && chAck == 0 && chDone == 0, "R11 outputs quiet after reset", {busReq, chAck, chDone}, 0);

    // vector table: R1 R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      automatic vec_t t = VECS[v];
      automatic int cntN = (t.cnt == 0) ? (1 << CW) : int'(t.cnt);
      configure(t.ch, t.src, t.dst, t.sInc, t.dInc, t.size, t.cnt, t.circ, 1'b1);
      for (int k = 0; k < int'(t.items); k++) begin
        automatic int idx = k % cntN;
        automatic logic [31:0] step = 32'(1) << t.size;
        automatic logic [31:0] eS = t.src + (t.sInc ? 32'(idx) * step : 32'd0);
        automatic logic [31:0] eD = t.dst + (t.dInc ? 32'(idx) * step : 32'd0);
        automatic logic [31:0] rdv = {eS[15:0], 8'(v), 8'(k)};
        // R7: idx wraps to 0 after the last item when circular
        serve(t.ch, eS, eD, t.size, int'(t.wR), int'(t.wW), idx == cntN - 1, rdv);
      end
      if (!t.circ) expectSilent(t.ch, "R8 stopped channel ignores request");
    end

    // R9 priority, R10 waiting request
    configure(2'd1, 32'h0000_C000, 32'h0000_C100, 1'b1, 1'b1, 2'd2, 4'd2, 1'b0, 1'b1);
    configure(2'd2, 32'h0000_D000, 32'h0000_D100, 1'b1, 1'b1, 2'd2, 4'd2, 1'b0, 1'b1);
    chReq[2] = 1'b1;
    serve(2'd1, 32'h0000_C000, 32'h0000_C100, 2'd2, 0, 0, 1'b0, 32'h1111_2222);
    chk(chReq[2] && !busReq && chAck == 0, "R10 second channel still waiting after first ack", {busReq, chAck}, 0);
    serve(2'd2, 32'h0000_D000, 32'h0000_D100, 2'd2, 0, 0, 1'b0, 32'h3333_4444);

    // R9 disabled channel
    configure(2'd3, 32'h0000_E000, 32'h0000_E100, 1'b1, 1'b1, 2'd0, 4'd3, 1'b0, 1'b0);
    expectSilent(2'd3, "R9 disabled channel ignored");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule